// File: doc/BRIEF.md
# PCI Interrupt Swizzle Aggregator

This block merges level-sensitive interrupt requests from every device on a PCI bus onto the four shared bus interrupt lines. Each request is an event. It carries a device/function number, the device pin it concerns (INTA..INTD, encoded 0..3) and the new level of that pin. The block rotates the pin by the device's slot number to pick a bus line. It remembers the last level seen from every (device/function, pin) source and keeps one counter of asserting sources for each bus line. A line is driven high while its counter is nonzero, so each line behaves as a wired-OR of every source routed to it.

A compile-time parameter picks one of three routing variants: the plain slot rotation, the rotation with the slot reduced by one, or a direct mapping with no rotation. A synchronous clear input wipes every stored level and every counter. It is meant for the moment the bus is re-registered.

Top module: `pci_irq_swizzle`

## Requirements
- R1: With MAP_MODE = MAP_SLOT (0), slot = devfn >> 3 and the bus line is (pin + slot) mod 4.
- R2: With MAP_MODE = MAP_SLOT_M1 (1), the bus line is (pin + slot − 1) mod 4.
- R3: With MAP_MODE = MAP_DIRECT (2), the bus line equals the pin number, whatever the devfn.
- R4: An event that repeats the level already stored for its source leaves every bus line count unchanged. For example, raising a source twice and then lowering it once returns its line to low.
- R5: An accepted event changes its line's counter by (new level − stored level) and then overwrites the stored level with the new one.
- R6: bus_irq[n] is high exactly when at least one source routed to line n holds level 1. Lowering one of two such sources keeps the line high.
- R7: Reset clears all stored levels and counters, so bus_irq = 0. A cycle with bus_clear high does the same and overrides an event presented in that same cycle.
- R8: An event is taken only in a cycle with evt_valid high, and bus_irq reflects it after that clock edge. Inputs presented with evt_valid low have no effect.
- R9: Each counter holds every possible source count (up to 4 × NUM_DEVFN) without overflow and never decrements below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clear | input | 1 | Synchronous clear of all source state and counters |
| evt_valid | input | 1 | Event strobe |
| evt_devfn | input | DEVFN_W (8) | Device/function number of the event |
| evt_pin | input | 2 | Device pin, 0 = INTA .. 3 = INTD |
| evt_level | input | 1 | New level of that pin |
| bus_irq | output | 4 | Levels of the four bus interrupt lines |

## Verification
Two functions can land in one cycle: the clear, and an event that would otherwise update a counter and a stored level. The bench provokes this by raising a source in the same cycle as bus_clear. It expects all lines low afterwards. It then expects that raising and lowering the same source leaves its line low, which would not hold if the event's stored level had survived the clear. Every source of a full 256-entry configuration is swept on its own, and then all sources together with duplicate levels, across three instances that each use one routing variant. Each result is compared with counts the bench computes itself.

// File: rtl/pci_swz_pkg.sv
package pci_swz_pkg;

    localparam int NUM_LINES = 4;

    typedef enum logic [1:0] {
        MAP_SLOT    = 2'd0,
        MAP_SLOT_M1 = 2'd1,
        MAP_DIRECT  = 2'd2
    } map_mode_e;

endpackage

// File: rtl/pci_swz_map.sv
module pci_swz_map
    import pci_swz_pkg::*;
#(
    parameter map_mode_e MAP_MODE = MAP_SLOT,
    parameter int        DEVFN_W  = 8
) (
    input  logic [DEVFN_W-1:0] devfn_i,
    input  logic [1:0]         pin_i,
    output logic [1:0]         line_o
);
    // Only the two low bits of the slot matter modulo four.
    logic [1:0] slot_lo;
    assign slot_lo = devfn_i[4:3];

    generate
        if (MAP_MODE == MAP_DIRECT) begin : g_direct
            assign line_o = pin_i;
        end else if (MAP_MODE == MAP_SLOT_M1) begin : g_slot_m1
            assign line_o = pin_i + slot_lo - 2'd1;
        end else begin : g_slot
            assign line_o = pin_i + slot_lo;
        end
    endgenerate
endmodule

// File: rtl/pci_swz_state.sv
module pci_swz_state #(
    parameter int NUM_SRC = 1024,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             wr_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             lvl_i,
    output logic             prev_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] bits;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.bits = '0;
        end else if (wr_i) begin
            st_d.bits[idx_i] = lvl_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prev_o = st_q.bits[idx_i];

    // R5: the stored level is overwritten by the accepted event
    p_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clear_i) |=> (st_q.bits[$past(idx_i)] == $past(lvl_i)));

    // R7: clear empties the whole array
    p_clear_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (st_q.bits == '0));
endmodule

// File: rtl/pci_swz_count.sv
module pci_swz_count
    import pci_swz_pkg::*;
#(
    parameter int CNT_W   = 11,
    parameter int MAX_CNT = 1024
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 upd_i,
    input  logic [1:0]           line_i,
    input  logic                 up_i,
    input  logic                 dn_i,
    output logic [NUM_LINES-1:0] irq_o
);
    typedef struct packed {
        logic [NUM_LINES-1:0][CNT_W-1:0] cnt;
    } cs_t;

    cs_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        if (clear_i) begin
            cs_d.cnt = '0;
        end else if (upd_i) begin
            for (int n = 0; n < NUM_LINES; n++) begin
                if (line_i == n[1:0]) begin
                    if (up_i)      cs_d.cnt[n] = cs_q.cnt[n] + 1'b1;
                    else if (dn_i) cs_d.cnt[n] = cs_q.cnt[n] - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
            assign irq_o[g] = |cs_q.cnt[g];

            // R9: a decrement never finds the counter empty
            p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (upd_i && !clear_i && dn_i && line_i == g) |-> (cs_q.cnt[g] != '0));

            // R9: an increment never passes the source population
            p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (upd_i && !clear_i && up_i && line_i == g) |-> (cs_q.cnt[g] < CNT_W'(MAX_CNT)));
        end
    endgenerate
endmodule

// File: rtl/pci_irq_swizzle.sv
module pci_irq_swizzle
    import pci_swz_pkg::*;
#(
    parameter int        NUM_DEVFN = 256,
    parameter map_mode_e MAP_MODE  = MAP_SLOT,
    localparam int DEVFN_W = $clog2(NUM_DEVFN),
    localparam int NUM_SRC = NUM_DEVFN * 4,
    localparam int IDX_W   = $clog2(NUM_SRC),
    localparam int CNT_W   = $clog2(NUM_SRC) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_clear,
    input  logic               evt_valid,
    input  logic [DEVFN_W-1:0] evt_devfn,
    input  logic [1:0]         evt_pin,
    input  logic               evt_level,
    output logic [3:0]         bus_irq
);
    logic [1:0]       line;
    logic [IDX_W-1:0] src_idx;
    logic             prev_lvl;
    logic             accept;
    logic             step_up;
    logic             step_dn;

    assign src_idx = {evt_devfn, evt_pin};
    assign accept  = evt_valid && !bus_clear;
    assign step_up = evt_level && !prev_lvl;
    assign step_dn = !evt_level && prev_lvl;

    pci_swz_map #(
        .MAP_MODE (MAP_MODE),
        .DEVFN_W  (DEVFN_W)
    ) map_i (
        .devfn_i (evt_devfn),
        .pin_i   (evt_pin),
        .line_o  (line)
    );

    pci_swz_state #(
        .NUM_SRC (NUM_SRC)
    ) state_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (bus_clear),
        .wr_i    (evt_valid),
        .idx_i   (src_idx),
        .lvl_i   (evt_level),
        .prev_o  (prev_lvl)
    );

    pci_swz_count #(
        .CNT_W   (CNT_W),
        .MAX_CNT (NUM_SRC)
    ) count_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (bus_clear),
        .upd_i   (accept),
        .line_i  (line),
        .up_i    (step_up),
        .dn_i    (step_dn),
        .irq_o   (bus_irq)
    );

    // R6: an asserting event leaves its line high after the edge
    p_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && evt_level) |=> bus_irq[$past(line)]);

    // R7: clear drops every line
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_clear |=> (bus_irq == 4'b0000));

    // R8: no strobe, no change
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_valid && !bus_clear) |=> $stable(bus_irq));

    // R4: a repeated level does not move the lines
    p_repeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (evt_level == prev_lvl)) |=> $stable(bus_irq));
endmodule

// File: tb/pci_irq_swizzle_tb_top.sv
module pci_irq_swizzle_tb_top;
    import pci_swz_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_clear = 1'b0;
    logic       evt_valid = 1'b0;
    logic [7:0] evt_devfn = '0;
    logic [1:0] evt_pin = '0;
    logic       evt_level = 1'b0;
    logic [3:0] irq0, irq1, irq2;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // model state: [instance][line] counters, [instance][devfn][pin] levels
    int cnt_m [3][4];
    bit lvl_m [3][256][4];

    always #2 clk = ~clk;

    pci_irq_swizzle #(.NUM_DEVFN(256), .MAP_MODE(MAP_SLOT)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_clear(bus_clear), .evt_valid(evt_valid),
        .evt_devfn(evt_devfn), .evt_pin(evt_pin), .evt_level(evt_level), .bus_irq(irq0));
    pci_irq_swizzle #(.NUM_DEVFN(256), .MAP_MODE(MAP_SLOT_M1)) dut_m1_i (
        .clk(clk), .rst_n(rst_n), .bus_clear(bus_clear), .evt_valid(evt_valid),
        .evt_devfn(evt_devfn), .evt_pin(evt_pin), .evt_level(evt_level), .bus_irq(irq1));
    pci_irq_swizzle #(.NUM_DEVFN(256), .MAP_MODE(MAP_DIRECT)) dut_id_i (
        .clk(clk), .rst_n(rst_n), .bus_clear(bus_clear), .evt_valid(evt_valid),
        .evt_devfn(evt_devfn), .evt_pin(evt_pin), .evt_level(evt_level), .bus_irq(irq2));

    function automatic int exp_line(int k, int devfn, int pin);
        int slot = devfn >> 3;
        if (k == 0) return (pin + slot) % 4;        // R1
        if (k == 1) return (pin + slot + 3) % 4;    // R2
        return pin;                                 // R3
    endfunction

    function automatic logic [3:0] exp_irq(int k);
        logic [3:0] v;
        for (int n = 0; n < 4; n++) v[n] = (cnt_m[k][n] != 0);
        return v;
    endfunction

    function automatic logic [3:0] got_irq(int k);
        if (k == 0) return irq0;
        if (k == 1) return irq1;
        return irq2;
    endfunction

    task automatic model_clear();
        for (int k = 0; k < 3; k++) begin
            for (int n = 0; n < 4; n++) cnt_m[k][n] = 0;
            for (int d = 0; d < 256; d++)
                for (int p = 0; p < 4; p++) lvl_m[k][d][p] = 1'b0;
        end
    endtask

    task automatic check_all(string tag);
        for (int k = 0; k < 3; k++) begin
            checks++;
            if (got_irq(k) !== exp_irq(k)) begin
                failures++;
                $display("FAIL %s inst=%0d devfn=%0d pin=%0d actual=%b expected=%b",
                         tag, k, evt_devfn, evt_pin, got_irq(k), exp_irq(k));
            end
        end
    endtask

    // one cycle of stimulus, model update after the edge, check at the next negedge
    task automatic ev(int devfn, int pin, bit lvl, bit vld, bit clr, string tag);
        @(negedge clk);
        evt_devfn = 8'(devfn);
        evt_pin   = 2'(pin);
        evt_level = lvl;
        evt_valid = vld;
        bus_clear = clr;
        @(negedge clk);
        evt_valid = 1'b0;
        bus_clear = 1'b0;
        if (clr) begin
            model_clear();
        end else if (vld) begin
            for (int k = 0; k < 3; k++) begin
                int ln = exp_line(k, devfn, pin);
                cnt_m[k][ln] += int'(lvl) - int'(lvl_m[k][devfn][pin]);
                lvl_m[k][devfn][pin] = lvl;
            end
        end
        check_all(tag);
    endtask

    initial begin : watchdog
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        model_clear();
        repeat (3) @(negedge clk);
        check_all("R7 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R7 after reset");

        // isolated sweep: each source alone, mapping R1 R2 R3, update timing R8
        for (int d = 0; d < 256; d++)
            for (int p = 0; p < 4; p++) begin
                ev(d, p, 1'b1, 1'b1, 1'b0, "R1 R2 R3 R8 raise");
                ev(d, p, 1'b0, 1'b1, 1'b0, "R5 lower");
            end

        // strobe low has no effect
        ev(9, 2, 1'b1, 1'b0, 1'b0, "R8 no strobe");

        // repeated levels do not disturb the counts
        ev(16, 1, 1'b1, 1'b1, 1'b0, "R4 first raise");
        ev(16, 1, 1'b1, 1'b1, 1'b0, "R4 repeat raise");
        ev(16, 1, 1'b0, 1'b1, 1'b0, "R4 single lower");
        ev(16, 1, 1'b0, 1'b1, 1'b0, "R4 repeat lower");

        // wired-OR: two sources on one line (slot 0 pin 1 and slot 1 pin 0)
        ev(0, 1, 1'b1, 1'b1, 1'b0, "R6 source a");
        ev(8, 0, 1'b1, 1'b1, 1'b0, "R6 source b");
        ev(0, 1, 1'b0, 1'b1, 1'b0, "R6 one left");
        ev(8, 0, 1'b0, 1'b1, 1'b0, "R6 none left");

        // bulk: every source raised (with a duplicate), then lowered in reverse
        for (int d = 0; d < 256; d++)
            for (int p = 0; p < 4; p++) begin
                ev(d, p, 1'b1, 1'b1, 1'b0, "R9 bulk raise");
                if (d % 37 == 0) ev(d, p, 1'b1, 1'b1, 1'b0, "R4 bulk repeat");
            end
        for (int d = 255; d >= 0; d--)
            for (int p = 3; p >= 0; p--)
                ev(d, p, 1'b0, 1'b1, 1'b0, "R5 R6 bulk lower");

        // clear with a simultaneous event: clear wins, state wiped
        ev(40, 3, 1'b1, 1'b1, 1'b0, "R7 pre-clear");
        ev(41, 2, 1'b1, 1'b1, 1'b1, "R7 clear with event");
        ev(41, 2, 1'b1, 1'b1, 1'b0, "R7 raise after clear");
        ev(41, 2, 1'b0, 1'b1, 1'b0, "R7 lower after clear");
        ev(40, 3, 1'b0, 1'b1, 1'b0, "R7 stale source ignored");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule